// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Peripheral

This block is a multiplier and accumulator that sits on a simple register bus, next to a processor that has no multiply instruction of its own. Software loads a first operand, and the register it writes picks one of four operations: unsigned product, signed product, unsigned accumulate or signed accumulate. Writing the second operand starts the arithmetic. The 32-bit result and a 16-bit extension word can then be read on the very next bus access, with no wait states and no busy flag to poll.

Each operand write is either a full word or a byte. A byte is widened to 16 bits, with zeros in the unsigned operations and with its sign bit in the signed ones. Every mix of operand sizes (16x16, 16x8, 8x16, 8x8) therefore goes through the same datapath. The first operand stays in its register, so a run of second-operand writes reuses it, for example to scale one coefficient by several samples. The result words can be written, so software can load a starting value for an accumulation.

Top module: `regbus_mac`

## Requirements
- R1: Word offsets 0, 1, 2 and 3 all hold the first operand. A write there chooses the operation by offset: 0 unsigned product, 1 signed product, 2 unsigned accumulate, 3 signed accumulate (bit 0 of the offset means signed, bit 1 means accumulate). Offset 4 is the second operand, 5 the low result word, 6 the high result word and 7 the extension word. A read of any offset from 0 to 3 returns the first operand.
- R2: The new result and extension word are readable on the clock cycle right after the clock edge that takes the second-operand write.
- R3: The unsigned product gives the 32-bit product of the two operands taken as unsigned, and sets the extension word to 0x0000.
- R4: The signed product gives the 32-bit two's-complement product. The extension word becomes 0xFFFF when that product is negative and 0x0000 otherwise.
- R5: Unsigned accumulate adds the unsigned product to the 32-bit result, modulo 2^32. The extension word becomes the carry out of that addition (0x0001 or 0x0000).
- R6: Signed accumulate adds the signed product to the result, modulo 2^32. The extension word becomes 0xFFFF when bit 31 of the new result is set and 0x0000 otherwise.
- R7: With the byte flag high, an operand write takes only wdata[7:0]. The byte is zero-extended in the unsigned operations and sign-extended in the signed ones. For the second operand, the operation chosen by the last first-operand write decides.
- R8: The first operand and the chosen operation stay as they are across any number of second-operand writes.
- R9: Writes to offsets 5 and 6 load the low and high result words, so the next accumulation starts from that value. A byte write there zero-extends the byte.
- R10: A write to offset 7 has no effect; the extension word keeps its value.
- R11: After reset every register reads 0x0000 and the unsigned product is the selected operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (3) | Word offset of the register accessed |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_byte | input | 1 | High for a byte write (low byte of bus_wdata only) |
| bus_rdata | output | DATA_W (16) | Read data for bus_addr, combinational |

## Verification
The result, extension word and first operand are held state, and every later operation reads them again. A wrong value there can only be seen when software reads the registers. A stale or wrongly extended operand, or a missing carry, therefore shows up at the first read of the result after the trigger, one cycle after the write. A corrupted accumulator shows again in every later accumulate of the chain. The bench keeps a behavioural model of every register and compares each read against it. It does so right after every trigger and after preloads, byte writes and writes to the extension word.

// File: rtl/mac_pkg.sv
package mac_pkg;

   // offset bit 0 = signed, offset bit 1 = accumulate
   typedef enum logic [1:0] {
      OP_MPY  = 2'd0,
      OP_MPYS = 2'd1,
      OP_MAC  = 2'd2,
      OP_MACS = 2'd3
   } mac_op_e;

   localparam int unsigned REG_OPB = 4;
   localparam int unsigned REG_RLO = 5;
   localparam int unsigned REG_RHI = 6;
   localparam int unsigned REG_EXT = 7;

   function automatic logic op_is_signed(mac_op_e op);
      return op[0];
   endfunction

   function automatic logic op_is_acc(mac_op_e op);
      return op[1];
   endfunction

endpackage

// File: rtl/mac_opnd_ext.sv
module mac_opnd_ext #(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] din,
   input  logic              byte_mode,
   input  logic              sgn,
   output logic [DATA_W-1:0] dout
);
   localparam int unsigned HALF = DATA_W / 2;

   always_comb begin
      if (byte_mode)
         dout = {{HALF{sgn & din[HALF-1]}}, din[HALF-1:0]};
      else
         dout = din;
   end
endmodule

// File: rtl/mac_arith.sv
module mac_arith
   import mac_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0]   opa,
   input  logic [DATA_W-1:0]   opb,
   input  mac_op_e             op,
   input  logic [2*DATA_W-1:0] acc_in,
   output logic [2*DATA_W-1:0] res_out,
   output logic [DATA_W-1:0]   ext_out
);
   localparam int unsigned RES_W = 2 * DATA_W;

   logic [RES_W-1:0] a_wide;
   logic [RES_W-1:0] b_wide;
   logic [RES_W-1:0] prod;
   logic [RES_W:0]   sum;
   logic             sgn;

   always_comb begin
      sgn    = op_is_signed(op);
      a_wide = {{DATA_W{sgn & opa[DATA_W-1]}}, opa};
      b_wide = {{DATA_W{sgn & opb[DATA_W-1]}}, opb};
      // low RES_W bits of the widened product equal the signed product
      prod   = a_wide * b_wide;
      sum    = {1'b0, acc_in} + {1'b0, prod};
      res_out = op_is_acc(op) ? sum[RES_W-1:0] : prod;
      unique case (op)
         OP_MPY:  ext_out = '0;
         OP_MPYS: ext_out = {DATA_W{prod[RES_W-1]}};
         OP_MAC:  ext_out = {{(DATA_W-1){1'b0}}, sum[RES_W]};
         OP_MACS: ext_out = {DATA_W{sum[RES_W-1]}};
         default: ext_out = '0;
      endcase
   end
endmodule

// File: rtl/regbus_mac.sv
module regbus_mac
   import mac_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_byte,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int unsigned RES_W = 2 * DATA_W;
   localparam int unsigned N_EXT = 3;   // opa, opb, result preload

   generate
      if ((DATA_W % 2) != 0 || DATA_W < 4) begin : g_bad_width
         $error("regbus_mac: DATA_W must be even and at least 4");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("regbus_mac: ADDR_W must be at least 3");
      end
   endgenerate

   logic [DATA_W-1:0] opa_q, opb_q, ext_q;
   logic [RES_W-1:0]  res_q;
   mac_op_e           op_q;

   logic wr_opa, wr_opb, wr_rlo, wr_rhi;
   logic [N_EXT-1:0]  ext_sgn;
   logic [DATA_W-1:0] ext_val [N_EXT];
   logic [RES_W-1:0]  arith_res;
   logic [DATA_W-1:0] arith_ext;

   always_comb begin
      wr_opa = bus_we && (bus_addr[ADDR_W-1:2] == '0);
      wr_opb = bus_we && (bus_addr == ADDR_W'(REG_OPB));
      wr_rlo = bus_we && (bus_addr == ADDR_W'(REG_RLO));
      wr_rhi = bus_we && (bus_addr == ADDR_W'(REG_RHI));
      ext_sgn[0] = bus_addr[0];          // signedness of the new operation
      ext_sgn[1] = op_is_signed(op_q);   // second operand follows stored operation
      ext_sgn[2] = 1'b0;                 // result preload is zero-extended
   end

   generate
      for (genvar gi = 0; gi < N_EXT; gi++) begin : g_ext
         mac_opnd_ext #(.DATA_W(DATA_W)) u_ext (
            .din       (bus_wdata),
            .byte_mode (bus_byte),
            .sgn       (ext_sgn[gi]),
            .dout      (ext_val[gi])
         );
      end
   endgenerate

   mac_arith #(.DATA_W(DATA_W)) u_arith (
      .opa     (opa_q),
      .opb     (ext_val[1]),
      .op      (op_q),
      .acc_in  (res_q),
      .res_out (arith_res),
      .ext_out (arith_ext)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opa_q <= '0;
         opb_q <= '0;
         ext_q <= '0;
         res_q <= '0;
         op_q  <= OP_MPY;
      end else begin
         if (wr_opa) begin
            opa_q <= ext_val[0];
            op_q  <= mac_op_e'(bus_addr[1:0]);
         end
         if (wr_opb) begin
            opb_q <= ext_val[1];
            res_q <= arith_res;
            ext_q <= arith_ext;
         end
         if (wr_rlo) res_q[DATA_W-1:0]     <= ext_val[2];
         if (wr_rhi) res_q[RES_W-1:DATA_W] <= ext_val[2];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr[ADDR_W-1:2] == '0)          bus_rdata = opa_q;
      else if (bus_addr == ADDR_W'(REG_OPB))   bus_rdata = opb_q;
      else if (bus_addr == ADDR_W'(REG_RLO))   bus_rdata = res_q[DATA_W-1:0];
      else if (bus_addr == ADDR_W'(REG_RHI))   bus_rdata = res_q[RES_W-1:DATA_W];
      else if (bus_addr == ADDR_W'(REG_EXT))   bus_rdata = ext_q;
   end

   AST_MPY_EXT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_opb && op_q == OP_MPY) |=> (ext_q == '0)); // R3
   AST_MPYS_EXT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_opb && op_q == OP_MPYS) |=> (ext_q == {DATA_W{res_q[RES_W-1]}})); // R4
   AST_MAC_CARRY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_opb && op_q == OP_MAC) |=> (ext_q == DATA_W'(res_q < $past(res_q)))); // R5
   AST_MACS_EXT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_opb && op_q == OP_MACS) |=> (ext_q == {DATA_W{res_q[RES_W-1]}})); // R6
   AST_OPA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_opb) |=> ($stable(opa_q) && $stable(op_q))); // R8
   AST_EXT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(REG_EXT)) |=> $stable(ext_q)); // R10
   AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we) |=> $stable(res_q)); // R2
endmodule

// File: tb/test_regbus_mac.sv
module test_regbus_mac;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_byte = 1'b0;
   logic [15:0] bus_rdata;

   int n_tests = 0;
   int n_fail  = 0;
   bit done = 0;

   // behavioural model
   bit [15:0] m_opa, m_opb, m_ext;
   bit [31:0] m_res;
   bit [1:0]  m_op;

   always #(CLK_PERIOD/2) clk = ~clk;

   regbus_mac i_regbus_mac (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_byte  (bus_byte),
      .bus_rdata (bus_rdata)
   );

   function automatic bit [15:0] widen(bit [15:0] d, bit byte_m, bit sg);
      if (!byte_m) return d;
      return (sg && d[7]) ? {8'hFF, d[7:0]} : {8'h00, d[7:0]};
   endfunction

   function automatic longint to_val(bit [15:0] v, bit sg);
      longint r;
      r = longint'(v);
      if (sg && v[15]) r = r - 65536;
      return r;
   endfunction

   function automatic bit [15:0] model_read(bit [2:0] a);
      case (a)
         3'd4: return m_opb;
         3'd5: return m_res[15:0];
         3'd6: return m_res[31:16];
         3'd7: return m_ext;
         default: return m_opa;
      endcase
   endfunction

   task automatic model_trigger();
      bit sg;
      longint p, s;
      bit [63:0] pbits, sbits;
      sg = m_op[0];
      p = to_val(m_opa, sg) * to_val(m_opb, sg);
      pbits = 64'(p);
      if (!m_op[1]) begin
         m_res = pbits[31:0];
         if (sg) m_ext = (p < 0) ? 16'hFFFF : 16'h0000;
         else    m_ext = 16'h0000;
      end else begin
         s = longint'(m_res) + longint'(pbits[31:0]);
         sbits = 64'(s);
         m_res = sbits[31:0];
         if (sg) m_ext = m_res[31] ? 16'hFFFF : 16'h0000;
         else    m_ext = {15'd0, sbits[32]};
      end
   endtask

   task automatic wr(bit [2:0] a, bit [15:0] d, bit byte_m = 0);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_byte = byte_m;
      @(negedge clk);
      bus_we = 1'b0; bus_byte = 1'b0;
      case (a)
         3'd0, 3'd1, 3'd2, 3'd3: begin
            m_op = a[1:0];
            m_opa = widen(d, byte_m, a[0]);
         end
         3'd4: begin
            m_opb = widen(d, byte_m, m_op[0]);
            model_trigger();
         end
         3'd5: m_res[15:0]  = widen(d, byte_m, 1'b0);
         3'd6: m_res[31:16] = widen(d, byte_m, 1'b0);
         default: ;
      endcase
   endtask

   task automatic chk(string req, bit [2:0] a, bit [15:0] exp);
      bus_addr = a;
      #1;
      n_tests++;
      if (bus_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, bus_rdata, exp);
      end
   endtask

   task automatic chk_model(string req);
      chk(req, 3'd5, model_read(3'd5));
      chk(req, 3'd6, model_read(3'd6));
      chk(req, 3'd7, model_read(3'd7));
   endtask

   initial begin
      bit [31:0] lcg;
      m_opa = 0; m_opb = 0; m_ext = 0; m_res = 0; m_op = 0;
      repeat (3) @(negedge clk);
      // R11 reset state
      for (int a = 0; a < 8; a++) chk("R11", 3'(a), 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 unsigned product, R2 read right after the trigger
      wr(3'd0, 16'd1234);
      wr(3'd4, 16'd5678);
      chk("R2", 3'd5, 16'hE9BC);
      chk("R3", 3'd6, 16'h006A);
      chk("R3", 3'd7, 16'h0000);
      wr(3'd0, 16'hFFFF);
      wr(3'd4, 16'hFFFF);
      chk("R3", 3'd5, 16'h0001);
      chk("R3", 3'd6, 16'hFFFE);

      // R4 signed product, R8 operand reuse
      wr(3'd1, 16'hFFFE);
      wr(3'd4, 16'd3);
      chk("R4", 3'd5, 16'hFFFA);
      chk("R4", 3'd6, 16'hFFFF);
      chk("R4", 3'd7, 16'hFFFF);
      wr(3'd4, 16'hFFFD);
      chk("R8", 3'd5, 16'h0006);
      chk("R4", 3'd7, 16'h0000);
      chk("R8", 3'd0, 16'hFFFE);
      // R1 offsets 1..3 also read the first operand, offset 4 the second
      chk("R1", 3'd1, 16'hFFFE);
      chk("R1", 3'd3, 16'hFFFE);
      chk("R1", 3'd4, 16'hFFFD);

      // R9 preload, R5 unsigned accumulate with carry
      wr(3'd5, 16'hFFFF);
      wr(3'd6, 16'hFFFF);
      chk("R9", 3'd6, 16'hFFFF);
      wr(3'd2, 16'd2);
      wr(3'd4, 16'd1);
      chk("R5", 3'd5, 16'h0001);
      chk("R5", 3'd6, 16'h0000);
      chk("R5", 3'd7, 16'h0001);
      wr(3'd4, 16'd3);
      chk("R5", 3'd5, 16'h0007);
      chk("R5", 3'd7, 16'h0000);

      // R6 signed accumulate
      wr(3'd5, 16'd5);
      wr(3'd6, 16'd0);
      wr(3'd3, 16'hFFFF);
      wr(3'd4, 16'd10);
      chk("R6", 3'd5, 16'hFFFB);
      chk("R6", 3'd6, 16'hFFFF);
      chk("R6", 3'd7, 16'hFFFF);
      wr(3'd4, 16'hFFF0);
      chk("R6", 3'd5, 16'h000B);
      chk("R6", 3'd7, 16'h0000);

      // R7 byte operands
      wr(3'd1, 16'h1280, 1'b1);
      chk("R7", 3'd0, 16'hFF80);
      wr(3'd4, 16'h55FF, 1'b1);
      chk("R7", 3'd4, 16'hFFFF);
      chk("R7", 3'd5, 16'h0080);
      chk("R7", 3'd7, 16'h0000);
      wr(3'd0, 16'h1280, 1'b1);
      chk("R7", 3'd0, 16'h0080);
      wr(3'd4, 16'hAB90, 1'b1);
      chk("R7", 3'd4, 16'h0090);
      chk("R7", 3'd5, 16'h4800);
      wr(3'd5, 16'hABCD, 1'b1);
      chk("R9", 3'd5, 16'h00CD);

      // R10 extension word ignores writes
      wr(3'd1, 16'hFFFF);
      wr(3'd4, 16'd1);
      wr(3'd7, 16'h1234);
      chk("R10", 3'd7, 16'hFFFF);

      // mixed sweep against the model
      lcg = 32'h1234_5678;
      for (int i = 0; i < 48; i++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         wr(3'(i % 4), lcg[31:16], lcg[3]);
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         wr(3'd4, lcg[31:16], lcg[5]);
         chk_model("R2");
         if (i % 8 == 7) wr(3'd4, lcg[15:0], 1'b0);
         if (i % 8 == 7) chk_model("R8");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule